// File: doc/BRIEF.md
# Unaligned Write-Burst Realigner

This block turns a stream of packed 32-bit elements into full-width 256-bit write beats for a memory bus. The destination is a byte address that software supplies at run time. The payload's first byte lands exactly on that address, even when the address is not a multiple of the beat width. Every input beat is moved up across byte lanes by the sub-beat part of the address. Bytes that spill past the top of an output beat are kept in a carry register and merged into the low lanes of the following beat. The block therefore keeps one full beat per clock in steady state, whatever the alignment.

A transfer starts with a start pulse carrying the byte address and a length counted in 32-bit elements. Input beats carry eight elements each; the last input beat may be partly filled. Each output beat comes with a beat-aligned bus address, per-byte write strobes and a last flag. The strobes clear the bytes below the start address in the head beat and the bytes past the payload's end in the tail beat, so memory around the written range is left untouched. A one-clock done pulse follows the acceptance of the final beat. After that pulse a new transfer may be loaded.

Top module: `ualign_realigner`

## Requirements
- R1: For offset o = start_addr mod 32 and length N elements, exactly ceil((o + 4N)/32) output beats are produced, and out_last is high on the final beat only.
- R2: Output beat m carries out_addr = (start_addr with its low 5 bits cleared) + 32*m, so the sub-beat part of the address is never dropped.
- R3: In the first beat, strobe bits below o are clear. Strobe bit i covers out_data bits [8i+7:8i].
- R4: In the last beat, with e = (o + 4N) mod 32, strobe bits at e and above are clear; if e is 0 the tail mask is all ones. In a single-beat transfer the head and tail masks are both applied.
- R5: Every beat between the first and the last has all 32 strobe bits set.
- R6: Byte b of element i (element i of input beat k sits at in_data bits [32j+31:32j] with i = 8k+j; byte b is bits [8b+7:8b] of the element) appears at absolute byte address start_addr + 4i + b. That is beat (o+4i+b) div 32, lane (o+4i+b) mod 32.
- R7: With o = 0 the block produces ceil(N/8) beats, with no extra carry beat. Each beat's strobed bytes equal the corresponding input beat unchanged.
- R8: While out_valid is high and out_ready is low, out_data, out_strb, out_addr and out_last hold their values into the next cycle.
- R9: done goes high for exactly one clock, in the cycle right after the last beat is accepted.
- R10: A start pulse is ignored while a transfer is in progress or when elem_count is 0. in_ready is low whenever no transfer is active.
- R11: With in_valid and out_ready held high, output beats are accepted on consecutive clocks, one beat per clock from first to last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Loads a new transfer when idle |
| start_addr | input | 32 | Destination byte address |
| elem_count | input | 16 | Transfer length in 32-bit elements |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 256 | Eight packed elements, element 0 in the low lanes |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts the output beat |
| out_data | output | 256 | Realigned beat data |
| out_strb | output | 32 | Per-byte write strobes |
| out_addr | output | 32 | Beat-aligned bus address |
| out_last | output | 1 | Final beat of the transfer |
| done | output | 1 | One-clock pulse after the final beat is accepted |

## Verification
The bench targets these cases:
- Offsets 1, 28 and 31 with one element. At offset 31 the element straddles two beats; a design that truncated the address, or lost the carry beat, would write at the wrong lane or emit one beat too few.
- A payload ending exactly on a beat boundary. A tail mask that treated an end byte of 0 as "no bytes" would clear every strobe of the final beat.
- Aligned transfers, to show that no spurious flush beat appears.
- Random sink and source stalls, to show that a stalled beat is neither altered nor repeated. Without them a realigner that advanced its carry on a stall would go unnoticed.
- A start pulse issued in mid-transfer must not disturb the job in flight.
- A zero-length start must leave the block idle.

// File: rtl/ualign_pkg.sv
package ualign_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH,
    ST_DRAIN
  } ra_state_e;
endpackage

// File: rtl/ualign_lane_shift.sv
module ualign_lane_shift #(
  parameter int BEAT_W = 256,
  parameter int OFF_W  = 5
) (
  input  logic [BEAT_W-1:0] din,
  input  logic [OFF_W-1:0]  offs,
  output logic [BEAT_W-1:0] lo,
  output logic [BEAT_W-1:0] hi
);
  logic [2*BEAT_W-1:0] ext;

  always_comb begin
    ext = {{BEAT_W{1'b0}}, din} << {offs, 3'b000};
    lo  = ext[BEAT_W-1:0];
    hi  = ext[2*BEAT_W-1:BEAT_W];
  end
endmodule

// File: rtl/ualign_strb_gen.sv
module ualign_strb_gen #(
  parameter int BEAT_BYTES = 32,
  parameter int OFF_W      = 5
) (
  input  logic [OFF_W-1:0]      offs,
  input  logic [OFF_W-1:0]      end_b,
  input  logic                  is_first,
  input  logic                  is_last,
  output logic [BEAT_BYTES-1:0] strb
);
  for (genvar g = 0; g < BEAT_BYTES; g++) begin : g_lane
    logic head_ok;
    logic tail_ok;
    assign head_ok = (OFF_W'(g) >= offs);
    assign tail_ok = (end_b == '0) || (OFF_W'(g) < end_b);
    assign strb[g] = (!is_first || head_ok) && (!is_last || tail_ok);
  end
endmodule

// File: rtl/ualign_realigner.sv
module ualign_realigner
  import ualign_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int ELEM_W = 32,
  parameter int LANES  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [ADDR_W-1:0]           start_addr,
  input  logic [CNT_W-1:0]            elem_count,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [ELEM_W*LANES-1:0]     in_data,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [ELEM_W*LANES-1:0]     out_data,
  output logic [ELEM_W*LANES/8-1:0]   out_strb,
  output logic [ADDR_W-1:0]           out_addr,
  output logic                        out_last,
  output logic                        done
);
  localparam int BEAT_W     = ELEM_W * LANES;
  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int ELEM_BYTES = ELEM_W / 8;
  localparam int OFF_W      = $clog2(BEAT_BYTES);
  localparam int TOT_W      = CNT_W + $clog2(ELEM_BYTES) + OFF_W;

  // Payload end position in bytes, counted from the first beat's lane 0.
  function automatic logic [TOT_W-1:0] span_bytes(input logic [OFF_W-1:0] o,
                                                  input logic [CNT_W-1:0] n);
    return TOT_W'(o) + TOT_W'(n) * TOT_W'(ELEM_BYTES);
  endfunction

  function automatic logic [CNT_W-1:0] beats_out(input logic [TOT_W-1:0] span);
    return CNT_W'((span + TOT_W'(BEAT_BYTES - 1)) >> OFF_W);
  endfunction

  function automatic logic [CNT_W-1:0] beats_in(input logic [CNT_W-1:0] n);
    return CNT_W'(({1'b0, n} + (CNT_W+1)'(LANES - 1)) / (CNT_W+1)'(LANES));
  endfunction

  ra_state_e              state_q;
  logic [OFF_W-1:0]       offs_q, end_q;
  logic [ADDR_W-1:0]      base_q;
  logic [CNT_W-1:0]       nout_q, nin_q, icnt_q, ocnt_q;
  logic [BEAT_W-1:0]      carry_q, od_q;
  logic [BEAT_BYTES-1:0]  os_q;
  logic [ADDR_W-1:0]      oa_q;
  logic                   ol_q, ov_q, done_q;

  // Named events used by the datapath and the assertions.
  logic                   start_ok, can_load, in_fire, out_fire, load_flush, load_any;
  logic                   first_beat, last_beat;
  logic [TOT_W-1:0]       req_span;
  logic [BEAT_W-1:0]      sh_lo, sh_hi;
  logic [BEAT_BYTES-1:0]  beat_strb;
  logic [ADDR_W-1:0]      beat_addr;

  assign req_span   = span_bytes(start_addr[OFF_W-1:0], elem_count);
  assign start_ok   = start && (state_q == ST_IDLE) && (elem_count != '0);
  assign can_load   = !ov_q || out_ready;
  assign in_ready   = (state_q == ST_RUN) && can_load;
  assign in_fire    = in_valid && in_ready;
  assign out_fire   = ov_q && out_ready;
  assign load_flush = (state_q == ST_FLUSH) && can_load;
  assign load_any   = in_fire || load_flush;
  assign first_beat = (ocnt_q == '0);
  assign last_beat  = (ocnt_q == nout_q - 1'b1);
  assign beat_addr  = base_q + (ADDR_W'(ocnt_q) << OFF_W);

  ualign_lane_shift #(.BEAT_W(BEAT_W), .OFF_W(OFF_W)) u_shift (
    .din (in_data),
    .offs(offs_q),
    .lo  (sh_lo),
    .hi  (sh_hi)
  );

  ualign_strb_gen #(.BEAT_BYTES(BEAT_BYTES), .OFF_W(OFF_W)) u_strb (
    .offs    (offs_q),
    .end_b   (end_q),
    .is_first(first_beat),
    .is_last (last_beat),
    .strb    (beat_strb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      offs_q  <= '0;
      end_q   <= '0;
      base_q  <= '0;
      nout_q  <= '0;
      nin_q   <= '0;
      icnt_q  <= '0;
      ocnt_q  <= '0;
      carry_q <= '0;
      od_q    <= '0;
      os_q    <= '0;
      oa_q    <= '0;
      ol_q    <= 1'b0;
      ov_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_DRAIN) && out_fire;

      if (load_any) begin
        ov_q   <= 1'b1;
        od_q   <= in_fire ? (sh_lo | carry_q) : carry_q;
        os_q   <= beat_strb;
        oa_q   <= beat_addr;
        ol_q   <= last_beat;
        ocnt_q <= ocnt_q + 1'b1;
      end else if (out_fire) begin
        ov_q <= 1'b0;
      end

      if (in_fire) begin
        carry_q <= sh_hi;
        icnt_q  <= icnt_q + 1'b1;
      end

      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          offs_q  <= start_addr[OFF_W-1:0];
          end_q   <= req_span[OFF_W-1:0];
          base_q  <= {start_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
          nout_q  <= beats_out(req_span);
          nin_q   <= beats_in(elem_count);
          icnt_q  <= '0;
          ocnt_q  <= '0;
          carry_q <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: if (in_fire && (icnt_q == nin_q - 1'b1)) begin
          state_q <= (nout_q != nin_q) ? ST_FLUSH : ST_DRAIN;
        end
        ST_FLUSH: if (can_load) state_q <= ST_DRAIN;
        ST_DRAIN: if (out_fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_strb  = os_q;
  assign out_addr  = oa_q;
  assign out_last  = ol_q;
  assign done      = done_q;

  // ---------------- assertions ----------------
  p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_last |-> ocnt_q == nout_q);

  p_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_any && first_beat |=> (out_strb & ~({BEAT_BYTES{1'b1}} << offs_q)) == '0);

  p_mid_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_any && !first_beat && !last_beat |=> &out_strb);

  p_no_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) && (offs_q == '0) |-> sh_hi == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_strb)
                               && $stable(out_addr) && $stable(out_last));

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_last |=> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !in_ready);
endmodule

// File: tb/ualign_realigner_bench.sv
module ualign_realigner_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [31:0]  start_addr;
  logic [15:0]  elem_count;
  logic         in_valid;
  logic         in_ready;
  logic [255:0] in_data;
  logic         out_valid;
  logic         out_ready;
  logic [255:0] out_data;
  logic [31:0]  out_strb;
  logic [31:0]  out_addr;
  logic         out_last;
  logic         done;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] elems [0:255];

  always #10 clk = ~clk;

  ualign_realigner u_ualign_realigner (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .elem_count(elem_count), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_strb(out_strb), .out_addr(out_addr),
    .out_last(out_last), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic int exp_beats(int o, int n);
    return (o + 4*n + 31) / 32;
  endfunction

  function automatic logic [31:0] exp_strb(int m, int o, int n);
    logic [31:0] s = '0;
    for (int l = 0; l < 32; l++) begin
      int p = 32*m + l - o;
      s[l] = (p >= 0) && (p < 4*n);
    end
    return s;
  endfunction

  function automatic logic [7:0] exp_byte(int m, int l, int o);
    int p = 32*m + l - o;
    logic [31:0] w = elems[p/4];
    return 8'(w >> (8*(p%4)));
  endfunction

  function automatic logic [255:0] make_beat(int k, int n);
    logic [255:0] b;
    for (int j = 0; j < 8; j++) begin
      int idx = 8*k + j;
      b[32*j +: 32] = (idx < n) ? elems[idx] : $urandom;
    end
    return b;
  endfunction

  // mode 0: free flow; mode 1: random stalls plus a stray start mid-transfer
  task automatic run_job(input logic [31:0] addr, input int n, input int mode);
    int o = int'(addr[4:0]);
    int nout = exp_beats(o, n);
    int nin = (n + 7) / 8;
    int ib = 0, m = 0, cyc = 0, first_acc = -1, last_acc = -1;
    bit seen_done = 0, hold_pend = 0;
    logic [255:0] h_data; logic [31:0] h_strb, h_addr; logic h_last;
    for (int i = 0; i < 256; i++) elems[i] = $urandom;
    @(negedge clk);
    start = 1'b1; start_addr = addr; elem_count = 16'(n);
    in_valid = 1'b0; out_ready = 1'b1;
    while (!seen_done && cyc < 2000) begin
      @(negedge clk);
      if (hold_pend)
        chk(out_data == h_data && out_strb == h_strb && out_addr == h_addr &&
            out_last == h_last, "R8", "stalled beat changed",
            {out_strb, out_addr, 192'(out_data)}, {h_strb, h_addr, 192'(h_data)});
      if (mode == 1 && cyc == 2) begin
        start = 1'b1; start_addr = addr + 32'h40; elem_count = 16'd3; // R10
      end else begin
        start = 1'b0;
      end
      out_ready = (mode == 1) ? ($urandom % 4 != 0) : 1'b1;
      in_valid  = (ib < nin) && ((mode == 1) ? ($urandom % 3 != 0) : 1'b1);
      in_data   = make_beat(ib, n);
      #5;
      if (done) begin
        seen_done = 1;
        chk(last_acc >= 0 && cyc == last_acc + 1, "R9", "done timing",
            256'(cyc), 256'(last_acc + 1));
      end
      if (in_valid && in_ready) ib++;
      if (out_valid && out_ready) begin
        logic [31:0] es = exp_strb(m, o, n);
        bit dok = 1;
        for (int l = 0; l < 32; l++)
          if (es[l] && out_data[8*l +: 8] != exp_byte(m, l, o)) dok = 0;
        chk(dok, (o == 0) ? "R7" : "R6", "beat data", out_data, 256'(m));
        chk(out_strb == es, (m == 0) ? "R3" : ((m == nout-1) ? "R4" : "R5"),
            "strobe", 256'(out_strb), 256'(es));
        chk(out_addr == {addr[31:5], 5'b0} + 32'(32*m), "R2", "beat address",
            256'(out_addr), 256'({addr[31:5], 5'b0} + 32'(32*m)));
        chk(out_last == (m == nout-1), "R1", "last flag",
            256'(out_last), 256'(m == nout-1));
        if (first_acc < 0) first_acc = cyc;
        last_acc = cyc;
        m++;
      end
      hold_pend = out_valid && !out_ready;
      h_data = out_data; h_strb = out_strb; h_addr = out_addr; h_last = out_last;
      cyc++;
    end
    if (!seen_done) chk(0, "R9", "job watchdog, no done", 256'(cyc), 256'(0));
    chk(m == nout, "R1", "beat count", 256'(m), 256'(nout));
    if (o == 0) chk(m == nin, "R7", "aligned beat count", 256'(m), 256'(nin));
    if (mode == 0)
      chk(last_acc - first_acc == nout - 1, "R11", "beat gap",
          256'(last_acc - first_acc), 256'(nout - 1));
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    #5;
    chk(!done, "R9", "done wider than one clock", 256'(done), 256'(0));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240613));
    rst_n = 1'b0; start = 1'b0; start_addr = '0; elem_count = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk(!out_valid && !in_ready && !done, "R10", "reset state",
        256'({out_valid, in_ready, done}), 256'(0));

    // zero-length start is ignored
    @(negedge clk);
    start = 1'b1; start_addr = 32'h0000_0104; elem_count = 16'd0; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #5;
      chk(!in_ready && !out_valid && !done, "R10", "zero-length start acted",
          256'({in_ready, out_valid, done}), 256'(0));
      @(negedge clk);
    end

    // directed corners
    run_job(32'h0000_1000, 16, 0);  // aligned, R7
    run_job(32'hC000_0001, 1, 0);   // single beat, head and tail, R4
    run_job(32'h0000_0010, 8, 0);   // half-beat offset, carry beat
    run_job(32'h0000_001C, 1, 0);   // ends exactly at beat end, R4
    run_job(32'h0000_001F, 1, 0);   // straddles two beats
    run_job(32'h0000_0004, 7, 0);   // single beat ending on boundary
    run_job(32'h0000_0000, 200, 1); // long aligned with stalls
    run_job(32'h0000_0023, 200, 1); // long unaligned with stalls

    for (int t = 0; t < 40; t++) begin
      logic [31:0] a = $urandom;
      int n = 1 + int'($urandom % 200);
      run_job(a, n, t % 2);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule